// File: doc/BRIEF.md
# Three-Wire EEPROM Command Sequencer

This block is the host-side controller for a three-wire serial EEPROM. A parallel request (command, address, write data, word organization and an optional extra-word count for reads) is taken through a valid/ready handshake. The block then drives chip select, the serial clock and the serial data line towards the memory, and samples the memory's data line. It assembles the start bit, the two-bit opcode and the address, shifts write data out or read data in, and closes the frame.

Program commands (write, erase, erase-all, write-all) need two extra steps. Chip select is dropped after the frame to start the internal cycle. Chip select is then raised again and the memory's data line is sampled until it reads high (ready). If ready is not seen within a programmable number of samples, the request ends with an error. Reads can continue over consecutive words with chip select held high. Each word is delivered with a one-cycle valid strobe, and every request ends with a one-cycle done pulse.

The serial clock is a divided system clock. Each clock phase, the chip-select setup time and each deselect gap last one divider period of `clk_div_i + 1` system cycles.

Top module: `eeprom3w_seq`

## Requirements
- R1: After reset and whenever idle, `cs_o` and `sk_o` are low, `req_ready_o` is high, and `done_o`, `err_o` and `rvalid_o` are low. `sk_o` is never high while `cs_o` is low.
- R2: Every frame begins with a 1, then a two-bit opcode, then the address MSB first. The opcodes are: read = 10, write = 01, erase = 11, extended = 00. The address is ADDR_W bits when `req_wide_i` = 0 (8-bit words) and ADDR_W-1 bits when `req_wide_i` = 1 (16-bit words).
- R3: `sk_o` high and low phases inside a frame each last `clk_div_i`+1 system cycles. `di_o` never changes while `sk_o` is high.
- R4: Extended commands use opcode 00 and put a code in the two most significant address bits, with the remaining address bits sent as 0. The codes are: enable = 11, disable = 00, erase-all = 10, write-all = 01. The command encoding on `req_cmd_i` is: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all.
- R5: Write and write-all append the data MSB first after the address: 16 bits in wide mode, or the low 8 bits of `req_wdata_i` in byte mode.
- R6: On a read, the bit returned during the last address clock is a dummy and is discarded. The following 16 (or 8) bits, sampled before each falling clock edge, form the word MSB first. Each word is presented on `rdata_o` with a one-cycle `rvalid_o` (byte mode zero-extends).
- R7: A read delivers `req_burst_i`+1 words with `cs_o` held high and no further address bits, so the frame is header plus (`req_burst_i`+1) word lengths of clocks.
- R8: After a program command's frame, `cs_o` goes low for at least one divider period and then high again. `do_i` is sampled once per divider period, and the request completes without error once a 1 is sampled.
- R9: If `do_i` stays low for max(`poll_limit_i`,1) samples, the request completes with `err_o` high alongside `done_o`, and `cs_o` is low.
- R10: A request is accepted when `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` is low until the request completes. `done_o` is a single-cycle pulse, and `cs_o` stays low for at least one divider period before completion.
- R11: `cs_o` is high for at least one divider period before the first rising edge of `sk_o` in a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_cmd_i | input | 3 | Command code (R4 encoding) |
| req_addr_i | input | ADDR_W | Word or byte address |
| req_wdata_i | input | DATA_W | Write data |
| req_wide_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| req_burst_i | input | BURST_W | Extra words for a read |
| clk_div_i | input | DIV_W | Divider: phase length minus one |
| poll_limit_i | input | POLL_W | Maximum ready samples |
| cs_o | output | 1 | Chip select |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data / ready from the memory |
| rdata_o | output | DATA_W | Read word |
| rvalid_o | output | 1 | Read word strobe |
| done_o | output | 1 | Request complete pulse |
| err_o | output | 1 | Ready timeout, valid with done |

## Verification
The bench uses the default ADDR_W of 7, DATA_W of 16 and BURST_W of 4, with divider values from 0 to 3. Divider values from 0 to 3 exercise both the one-cycle phase edge case and multi-cycle phases. Seven address bits give 64 words of 16 bits or 128 bytes, small enough that reads starting near the top address wrap within a short burst. A poll limit of 4 against a memory model held busy reaches the timeout. Busy times between 5 and 60 cycles against a limit of 200 keep normal program cycles inside the limit.

// File: rtl/eeprom3w_pkg.sv
package eeprom3w_pkg;
  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WEN   = 3'd3,
    CMD_WDIS  = 3'd4,
    CMD_ERAL  = 3'd5,
    CMD_WRAL  = 3'd6
  } cmd_e;

  function automatic logic [1:0] cmd_opcode(cmd_e c);
    case (c)
      CMD_READ:  return 2'b10;
      CMD_WRITE: return 2'b01;
      CMD_ERASE: return 2'b11;
      default:   return 2'b00;
    endcase
  endfunction

  // code carried in the top two address bits under opcode 00
  function automatic logic [1:0] ext_code(cmd_e c);
    case (c)
      CMD_WEN:  return 2'b11;
      CMD_ERAL: return 2'b10;
      CMD_WRAL: return 2'b01;
      default:  return 2'b00;
    endcase
  endfunction

  function automatic logic is_ext(cmd_e c);
    return !(c inside {CMD_READ, CMD_WRITE, CMD_ERASE});
  endfunction

  function automatic logic is_prog(cmd_e c);
    return c inside {CMD_WRITE, CMD_ERASE, CMD_ERAL, CMD_WRAL};
  endfunction

  function automatic logic has_data(cmd_e c);
    return c inside {CMD_WRITE, CMD_WRAL};
  endfunction
endpackage

// File: rtl/eeprom3w_tick.sv
module eeprom3w_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!en_i || cnt_q == div_i) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == div_i);
endmodule

// File: rtl/eeprom3w_shift.sv
module eeprom3w_shift #(
  parameter int TX_W = 26,
  parameter int RX_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TX_W-1:0] load_vec_i,
  input  logic            adv_i,
  input  logic            cap_i,
  input  logic            bit_i,
  output logic            ser_o,
  output logic [RX_W-1:0] par_o
);
  logic [TX_W-1:0] tx_q;
  logic [RX_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)     tx_q <= load_vec_i;
      else if (adv_i) tx_q <= {tx_q[TX_W-2:0], 1'b0};
      if (cap_i)      rx_q <= {rx_q[RX_W-2:0], bit_i};
    end
  end

  assign ser_o = tx_q[TX_W-1];
  assign par_o = rx_q;
endmodule

// File: rtl/eeprom3w_seq.sv
module eeprom3w_seq
  import eeprom3w_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int BURST_W = 4,
  parameter int DIV_W   = 8,
  parameter int POLL_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [2:0]         req_cmd_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic               req_wide_i,
  input  logic [BURST_W-1:0] req_burst_i,
  input  logic [DIV_W-1:0]   clk_div_i,
  input  logic [POLL_W-1:0]  poll_limit_i,
  output logic               cs_o,
  output logic               sk_o,
  output logic               di_o,
  input  logic               do_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HDR_W  = 3 + ADDR_W;
  localparam int TX_W   = HDR_W + DATA_W;
  localparam int BCNT_W = $clog2(TX_W + 1);
  localparam int RCNT_W = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SHIFT, S_READ, S_GAP, S_PSETUP, S_POLL, S_END
  } state_e;

  state_e              state_q;
  cmd_e                cmd_q, req_cmd;
  logic                cs_q, sk_q, wide_q, err_q, done_q, fail_q, rvalid_q;
  logic [BCNT_W-1:0]   bits_q, frame_len;
  logic [RCNT_W-1:0]   rbits_q, word_len;
  logic [BURST_W-1:0]  words_q;
  logic [POLL_W-1:0]   poll_q;
  logic                tick, accept, tx_adv, rx_cap;
  logic [ADDR_W-1:0]   afield;
  logic [DATA_W-1:0]   dfield;
  logic [TX_W-1:0]     dvec, frame;
  logic [DATA_W-1:0]   rx_word;

  assign req_cmd     = cmd_e'(req_cmd_i);
  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  // frame image, left aligned: start, opcode, address field, data
  always_comb begin
    if (is_ext(req_cmd))  afield = {ext_code(req_cmd), {(ADDR_W-2){1'b0}}};
    else if (req_wide_i)  afield = {req_addr_i[ADDR_W-2:0], 1'b0};
    else                  afield = req_addr_i;
    dfield = req_wide_i ? req_wdata_i : {req_wdata_i[HALF_W-1:0], {HALF_W{1'b0}}};
    dvec   = has_data(req_cmd) ? {{HDR_W{1'b0}}, dfield} : '0;
    if (req_wide_i) dvec = dvec << 1;
    frame  = {1'b1, cmd_opcode(req_cmd), afield, {DATA_W{1'b0}}} | dvec;
    frame_len = BCNT_W'(HDR_W) - BCNT_W'(req_wide_i)
              + (has_data(req_cmd) ? (req_wide_i ? BCNT_W'(DATA_W) : BCNT_W'(HALF_W))
                                   : BCNT_W'(0));
  end

  assign word_len = wide_q ? RCNT_W'(DATA_W) : RCNT_W'(HALF_W);
  assign tx_adv   = (state_q == S_SHIFT) && tick && sk_q;
  assign rx_cap   = (state_q == S_READ)  && tick && sk_q;

  eeprom3w_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != S_IDLE),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  eeprom3w_shift #(.TX_W(TX_W), .RX_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_vec_i (frame),
    .adv_i      (tx_adv),
    .cap_i      (rx_cap),
    .bit_i      (do_i),
    .ser_o      (di_o),
    .par_o      (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cmd_q    <= CMD_READ;
      cs_q     <= 1'b0;
      sk_q     <= 1'b0;
      wide_q   <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      rvalid_q <= 1'b0;
      bits_q   <= '0;
      rbits_q  <= '0;
      words_q  <= '0;
      poll_q   <= '0;
    end else begin
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      rvalid_q <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          cmd_q   <= req_cmd;
          wide_q  <= req_wide_i;
          words_q <= req_burst_i;
          bits_q  <= frame_len;
          err_q   <= 1'b0;
          cs_q    <= 1'b1;
          state_q <= S_SETUP;
        end
        S_SETUP: if (tick) state_q <= S_SHIFT;
        S_SHIFT: if (tick) begin
          if (!sk_q) sk_q <= 1'b1;
          else begin
            sk_q   <= 1'b0;
            bits_q <= bits_q - 1'b1;
            if (bits_q == BCNT_W'(1)) begin
              // dummy bit arrives on this last header clock: not captured
              if (cmd_q == CMD_READ) begin
                rbits_q <= word_len;
                state_q <= S_READ;
              end else begin
                cs_q    <= 1'b0;
                state_q <= is_prog(cmd_q) ? S_GAP : S_END;
              end
            end
          end
        end
        S_READ: if (tick) begin
          if (!sk_q) sk_q <= 1'b1;
          else begin
            sk_q    <= 1'b0;
            rbits_q <= rbits_q - 1'b1;
            if (rbits_q == RCNT_W'(1)) begin
              rvalid_q <= 1'b1;
              if (words_q == '0) begin
                cs_q    <= 1'b0;
                state_q <= S_END;
              end else begin
                words_q <= words_q - 1'b1;
                rbits_q <= word_len;
              end
            end
          end
        end
        S_GAP: if (tick) begin
          cs_q    <= 1'b1;
          state_q <= S_PSETUP;
        end
        S_PSETUP: if (tick) begin
          poll_q  <= '0;
          state_q <= S_POLL;
        end
        S_POLL: if (tick) begin
          if (do_i) begin
            cs_q    <= 1'b0;
            state_q <= S_END;
          end else if ({1'b0, poll_q} + 1'b1 >= {1'b0, poll_limit_i}) begin
            err_q   <= 1'b1;
            cs_q    <= 1'b0;
            state_q <= S_END;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        S_END: if (tick) begin
          done_q  <= 1'b1;
          fail_q  <= err_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs_o     = cs_q;
  assign sk_o     = sk_q;
  assign rvalid_o = rvalid_q;
  assign done_o   = done_q;
  assign err_o    = fail_q;
  assign rdata_o  = wide_q ? rx_word : {{(DATA_W-HALF_W){1'b0}}, rx_word[HALF_W-1:0]};
endmodule

// File: rtl/eeprom3w_seq_chk.sv
module eeprom3w_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic cs_o,
  input logic sk_o,
  input logic di_o,
  input logic done_o
);
  assert_sk_gated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sk_o);

  assert_di_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> $stable(di_o));

  assert_cs_setup_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sk_o) |-> $past(cs_o));

  assert_idle_deselect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cs_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind eeprom3w_seq eeprom3w_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cs_o        (cs_o),
  .sk_o        (sk_o),
  .di_o        (di_o),
  .done_o      (done_o)
);

// File: tb/tb_eeprom3w_seq.sv
module tb_eeprom3w_seq;
  localparam int AW = 7, DW = 16, BW = 4, VW = 8, PW = 16;
  localparam int NW = 2 ** (AW - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_ready, req_wide = 0;
  logic [2:0]    req_cmd = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0, rdata;
  logic [BW-1:0] req_burst = 0;
  logic [VW-1:0] clk_div = 0;
  logic [PW-1:0] poll_limit = 16'd200;
  logic          cs, sk, di, do_w, rvalid, done, err;

  eeprom3w_seq #(.ADDR_W(AW), .DATA_W(DW), .BURST_W(BW), .DIV_W(VW), .POLL_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_wide_i(req_wide), .req_burst_i(req_burst), .clk_div_i(clk_div),
    .poll_limit_i(poll_limit), .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(do_w),
    .rdata_o(rdata), .rvalid_o(rvalid), .done_o(done), .err_o(err));

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [NW];
  logic m_wide = 0, m_stuck = 0;
  int   m_busy_len = 20;
  logic m_init = 0, m_wen = 0, m_rd = 0, m_rdout = 0, m_csq = 0, m_skq = 0;
  int   m_bitn = 0, m_busy = 0, m_rptr = 0, m_rbit = 0, cyc = 0, busy_end = 0;
  logic [31:0] m_fr = 0, last_fr = 0;
  int   last_len = 0;

  function automatic int mget(int a, logic w);
    logic [DW-1:0] x;
    if (w) return int'(mem[a % NW]);
    x = mem[(a / 2) % NW];
    return (a % 2 == 0) ? int'(x[15:8]) : int'(x[7:0]);
  endfunction

  task automatic mset(int a, int d);
    if (m_wide) mem[a % NW] = DW'(d);
    else if (a % 2 == 0) mem[(a / 2) % NW][15:8] = d[7:0];
    else mem[(a / 2) % NW][7:0] = d[7:0];
  endtask

  task automatic m_exec();
    int aw, hl, dl, op, a, d, code;
    logic [31:0] h;
    bit has;
    aw = m_wide ? AW - 1 : AW; hl = 3 + aw; dl = m_wide ? DW : DW / 2;
    if (last_len > 32 || last_len < hl) return;
    h = last_fr >> (last_len - hl);
    op = int'((h >> aw) & 32'd3);
    a = int'(h & ((32'd1 << aw) - 1));
    d = int'(last_fr & ((32'd1 << dl) - 1));
    has = last_len >= hl + dl;
    if (op == 0) begin
      code = a >> (aw - 2);
      if (code == 3) m_wen = 1;
      else if (code == 0) m_wen = 0;
      else if (m_wen && (code == 2 || has)) begin
        for (int i = 0; i < NW; i++)
          mem[i] = (code == 2) ? '1 : (m_wide ? DW'(d) : {d[7:0], d[7:0]});
        m_busy = m_busy_len; busy_end = cyc + m_busy_len;
      end
    end else if (m_wen && ((op == 1 && has) || op == 3)) begin
      mset(a, (op == 3) ? 'hFFFF : d);
      m_busy = m_busy_len; busy_end = cyc + m_busy_len;
    end
  endtask

  always @(negedge clk) begin
    int aw, hl, dl;
    logic [DW-1:0] w;
    if (!m_init) begin
      for (int i = 0; i < NW; i++) mem[i] = DW'($urandom);
      m_init = 1;
    end
    cyc++;
    if (m_busy > 0) m_busy--;
    aw = m_wide ? AW - 1 : AW; hl = 3 + aw; dl = m_wide ? DW : DW / 2;
    if (cs && sk && !m_skq) begin
      m_bitn++;
      if (m_bitn <= 32) m_fr = {m_fr[30:0], di};
      if (m_bitn == hl && ((m_fr >> aw) & 32'd3) == 32'd2) begin
        m_rd = 1; m_rptr = int'(m_fr & ((32'd1 << aw) - 1)); m_rbit = 0;
        m_rdout = 0;  // dummy
      end else if (m_rd && m_bitn > hl) begin
        w = DW'(mget(m_rptr, m_wide));
        m_rdout = w[dl - 1 - m_rbit];
        m_rbit++;
        if (m_rbit == dl) begin m_rbit = 0; m_rptr = (m_rptr + 1) % (2 ** aw); end
      end
    end
    if (!cs && m_csq) begin
      if (m_bitn > 0) begin last_len = m_bitn; last_fr = m_fr; m_exec(); end
      m_bitn = 0; m_fr = 0; m_rd = 0;
    end
    m_csq = cs; m_skq = sk;
  end

  assign do_w = m_rd ? m_rdout : (m_busy == 0 && !m_stuck);

  // ---------------- timing monitor ----------------
  int tm_bad = 0, su_bad = 0, mon_run = 0, mon_cs = 0;
  logic mon_skq = 0, mon_di = 0, mon_seen = 0;
  always @(negedge clk) begin
    if (!cs) begin mon_seen = 0; mon_run = 0; mon_cs = 0; end
    else begin
      mon_cs++;
      if (sk && di !== mon_di) tm_bad++;
      if (sk != mon_skq) begin
        if (mon_skq && mon_run != int'(clk_div) + 1) tm_bad++;
        if (!mon_skq && mon_seen && mon_run != int'(clk_div) + 1) tm_bad++;
        if (sk && !mon_seen && mon_cs - 1 < int'(clk_div) + 1) su_bad++;
        if (sk) mon_seen = 1;
        mon_run = 1;
      end else mon_run++;
    end
    mon_skq = sk; mon_di = di;
  end

  // ---------------- expected frame ----------------
  function automatic logic [31:0] exp_hdr(int c, int a, logic w);
    int aw; logic [31:0] f; int op, code;
    aw = w ? AW - 1 : AW;
    op = (c == 0) ? 2 : (c == 1) ? 1 : (c == 2) ? 3 : 0;
    code = (c == 3) ? 3 : (c == 5) ? 2 : (c == 6) ? 1 : 0;
    f = 32'd1;
    f = (f << 2) | 32'(op);
    if (c >= 3) f = (f << aw) | (32'(code) << (aw - 2));
    else f = (f << aw) | (32'(a) & ((32'd1 << aw) - 1));
    return f;
  endfunction

  int rd_words [16];
  int nrd, done_cyc;
  logic last_err;

  task automatic run(input int c, input int a, input int d, input logic w, input int burst);
    m_wide = w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = 3'(c); req_addr = AW'(a); req_wdata = DW'(d); req_wide = w;
    req_burst = BW'(burst); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10 ready low after accept", req_ready, 0);
    nrd = 0;
    while (!done) begin
      if (rvalid && nrd < 16) begin rd_words[nrd] = int'(rdata); nrd++; end
      @(negedge clk);
    end
    last_err = err; done_cyc = cyc;
    @(negedge clk);
    chk(done == 0 && cs == 0, "R10 done single pulse, cs low", {done, cs}, 0);
  endtask

  task automatic check_frame(input int c, input int a, input int d, input logic w, input int burst);
    int aw, hl, dl, elen, sh; logic [31:0] got, exp;
    aw = w ? AW - 1 : AW; hl = 3 + aw; dl = w ? DW : DW / 2;
    elen = hl + ((c == 0) ? dl * (burst + 1) : (c == 1 || c == 6) ? dl : 0);
    chk(last_len == elen, (c == 0) ? "R7 frame length" : "R2 frame length", last_len, elen);
    sh = ((last_len > 32) ? 32 : last_len) - hl;
    if (sh < 0) sh = 0;
    got = last_fr >> sh;
    exp = exp_hdr(c, a, w);
    chk(got == exp, (c >= 3) ? "R4 extended header" : "R2 header", got, exp);
    if (c == 1 || c == 6) begin
      got = last_fr & ((32'd1 << dl) - 1);
      exp = 32'(d) & ((32'd1 << dl) - 1);
      chk(got == exp, "R5 data bits", got, exp);
    end
  endtask

  task automatic do_op(input int c, input int a, input int d, input logic w, input int burst);
    int t0, s0, aw, exp;
    t0 = tm_bad; s0 = su_bad;
    run(c, a, d, w, burst);
    check_frame(c, a, d, w, burst);
    chk(tm_bad == t0, "R3 clock phases and data hold", tm_bad - t0, 0);
    chk(su_bad == s0, "R11 select setup", su_bad - s0, 0);
    aw = w ? AW - 1 : AW;
    if (c == 0) begin
      chk(nrd == burst + 1, "R7 word count", nrd, burst + 1);
      for (int k = 0; k < nrd; k++) begin
        exp = mget((a + k) % (2 ** aw), w);
        chk(rd_words[k] == exp, "R6 read word", rd_words[k], exp);
      end
    end
    if (c == 1 || c == 2) begin
      exp = (c == 2) ? (w ? 'hFFFF : 'hFF) : (w ? d & 'hFFFF : d & 'hFF);
      chk(mget(a % (2 ** aw), w) == exp, "R8 program cycle launched", mget(a % (2 ** aw), w), exp);
    end
    if (c == 1 || c == 2 || c == 5 || c == 6) begin
      chk(last_err == 0, "R8 no error", last_err, 0);
      chk(done_cyc >= busy_end, "R8 done after ready", done_cyc, busy_end);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int c, a, d, b;
    logic w;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(cs == 0 && sk == 0 && req_ready == 1 && done == 0 && err == 0 && rvalid == 0,
        "R1 reset state", {cs, sk, req_ready, done, err, rvalid}, 6'b001000);
    rst_n = 1;
    @(negedge clk);
    chk(cs == 0 && sk == 0 && req_ready == 1, "R1 idle after reset", {cs, sk, req_ready}, 3'b001);

    // enable/disable codes
    do_op(4, 0, 0, 1, 0);
    do_op(3, 0, 0, 0, 0);
    do_op(3, 0, 0, 1, 0);
    // directed reads with wrap
    do_op(0, NW - 2, 0, 1, 3);
    do_op(0, 2 * NW - 1, 0, 0, 1);
    clk_div = 0;
    do_op(1, 5, 'hA5C3, 1, 0);
    do_op(0, 5, 0, 1, 0);
    do_op(1, 9, 'h7E, 0, 0);
    do_op(0, 9, 0, 0, 0);
    // all-array commands
    m_busy_len = 40;
    do_op(6, 0, 'h3C, 0, 0);
    do_op(0, 17, 0, 0, 2);
    do_op(5, 0, 0, 1, 0);
    do_op(0, 33, 0, 1, 1);

    // timeout
    m_stuck = 1; poll_limit = 4; clk_div = 1;
    run(2, 3, 0, 1, 0);
    chk(last_err == 1, "R9 timeout error", last_err, 1);
    chk(cs == 0, "R9 select released", cs, 0);
    m_stuck = 0; poll_limit = 200;
    do_op(2, 3, 0, 1, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      clk_div = VW'($urandom_range(0, 3));
      m_busy_len = $urandom_range(5, 60);
      w = 1'($urandom_range(0, 1));
      a = $urandom_range(0, 2 ** AW - 1);
      d = $urandom_range(0, 'hFFFF);
      b = $urandom_range(0, 3);
      case ($urandom_range(0, 9))
        0, 1, 2, 3: c = 0;
        4, 5, 6:    c = 1;
        7, 8:       c = 2;
        default:    c = 6;
      endcase
      if (w) a = a % NW;
      do_op(c, a, d, w, (c == 0) ? b : 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule